// File: doc/BRIEF.md
# UART Register Bank with Interrupts

This block is the bus-facing register file of a UART. A host issues word-indexed reads and writes over a simple valid/write-enable port, and the block holds the baud divisors, line control, control, FIFO level select and interrupt mask. It also keeps the receive error status and the raw interrupt status, and it drives one level-sensitive interrupt line. A 16-entry receive queue sits inside the block. Bytes reach that queue from the deserializer port, or from data writes when loopback is on.

Data writes leave on the transmitter port. Transmission is treated as instantaneous, so the flag register always shows an empty transmit side. The receive interrupt follows the fill level against a selectable trigger point, and a timeout-style bit shows that unread data is present. Fixed identification bytes occupy the top eight word offsets. Serial timing, modem lines and DMA are outside this block.

Top module: `uart_regbank`

## Requirements
- R1: After reset the level-select register reads 0x12, the divisor, line, control and mask registers read 0, the raw status reads 0, the flag register reads 0x90 and `irq` is low.
- R2: Writes keep only the implemented bits: fractional divisor (offset 0x0A) 0x3F, line control (0x0B) 0xFF, control (0x0C) 0xFFC7, level select (0x0D) 0x3F, mask (0x0E) 0x7FF. The integer divisor (0x09) keeps all 16 bits.
- R3: Every write to the data offset 0x00 sets raw status bit 5. When control bit 7 (loopback) is clear, the low byte appears on `tx_byte` with `tx_valid` high for one cycle. When it is set, the byte enters the receive queue and `tx_valid` stays low.
- R4: A byte offered to a full queue of 16 is dropped and sets bit 3 of the receive status (offset 0x01). This bit stays set until any write to 0x01. A data read returns the popped byte in bits 7:0 and the receive status in bits 11:8.
- R5: The flag register (0x06) always has bit 7 set. Bit 6 is set when the queue holds 16 bytes, and bit 4 is set when it holds none.
- R6: Raw bit 4 (receive) is set when an accepted byte raises the fill from below the trigger level to at or above it. It is cleared when a data read leaves the fill below the trigger. Level-select bits 5:3 choose the trigger: 0→2, 1→4, 2→8, 3→12, 4→14, and any other value →16. Raw bit 6 (timeout) is set by any accepted byte and cleared when a data read empties the queue.
- R7: A write to the clear offset 0x11 clears every raw status bit that is set in the written value. A read of 0x11 returns 0.
- R8: Offset 0x10 reads raw status AND mask (raw status is at 0x0F). `irq` is high exactly when that value is nonzero, from the cycle after the access that changes it.
- R9: Offsets 0x3F8 to 0x3FB read 0x11, 0x10, 0x24, 0x00. Offsets 0x3FC to 0x3FF read 0x0D, 0xF0, 0x05, 0xB1.
- R10: Writes to offsets 0x06, 0x0F, 0x10, the identification offsets and unassigned offsets change nothing. Reads from unassigned offsets return 0.
- R11: `rd_valid` rises one cycle after a read request, with `rd_data` for it. Data reads return bytes in arrival order. A data read from an empty queue returns 0 in bits 7:0 and does not change the fill.
- R12: While loopback is set, bytes on the deserializer port are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Word offset |
| bus_wdata | input | DATA_W | Write data |
| rd_valid | output | 1 | Read response valid |
| rd_data | output | DATA_W | Read response data |
| rx_in_valid | input | 1 | Received byte strobe from the deserializer |
| rx_in_byte | input | 8 | Received byte |
| tx_valid | output | 1 | Byte handed to the transmitter |
| tx_byte | output | 8 | Transmitted byte |
| irq | output | 1 | Level interrupt |

## Verification
A wrong fill count in the queue shows on the next flag or data read. Bits 6 and 4 flip at the wrong occupancy, bytes come back out of order, or the receive bit fires at the wrong push. A raw status bit that sticks or clears early reaches `irq` in the cycle after the access and reads back at 0x0F one read later. A lost overrun flag appears in bits 11:8 of the first data read after the overflow. The scoreboard pairs every read response with its expected value, so a miscompare is reported in the cycle that `rd_valid` rises.

// File: rtl/uart_regbank_pkg.sv
package uart_regbank_pkg;

  // word offsets decoded by the register bank
  localparam int OFF_DATA  = 'h00;
  localparam int OFF_ESTAT = 'h01;
  localparam int OFF_FLAGS = 'h06;
  localparam int OFF_IDIV  = 'h09;
  localparam int OFF_FDIV  = 'h0A;
  localparam int OFF_LINE  = 'h0B;
  localparam int OFF_CTRL  = 'h0C;
  localparam int OFF_LVL   = 'h0D;
  localparam int OFF_MASK  = 'h0E;
  localparam int OFF_RAW   = 'h0F;
  localparam int OFF_MSKD  = 'h10;
  localparam int OFF_CLR   = 'h11;

  // interrupt bit positions
  localparam int IRQ_RX = 4;
  localparam int IRQ_TX = 5;
  localparam int IRQ_RT = 6;

  localparam int LOOP_BIT   = 7;
  localparam int OVR_BIT    = 3;
  localparam int FL_TXEMPTY = 7;
  localparam int FL_RXFULL  = 6;
  localparam int FL_RXEMPTY = 4;

  localparam logic [15:0] CTRL_KEEP  = 16'hFFC7;
  localparam logic [15:0] LVL_RESET  = 16'h0012;
  localparam logic [31:0] ID_PERIPH  = 32'h0024_1011;
  localparam logic [31:0] ID_CELL    = 32'hB105_F00D;

  // receive trigger level chosen by the 3-bit selector
  function automatic int rx_trigger(input logic [2:0] sel, input int depth);
    case (sel)
      3'd0:    return depth / 8;
      3'd1:    return depth / 4;
      3'd2:    return depth / 2;
      3'd3:    return (depth * 3) / 4;
      3'd4:    return (depth * 7) / 8;
      default: return depth;
    endcase
  endfunction

endpackage

// File: rtl/uart_rxq.sv
module uart_rxq #(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [7:0]    push_byte,
  input  logic          pop,
  output logic          push_ok,
  output logic          pop_ok,
  output logic [7:0]    head,
  output logic [CW-1:0] cnt_q,
  output logic [CW-1:0] cnt_d
);

  logic [7:0]    store [DEPTH];
  logic [PW-1:0] wr_q, wr_d, rd_q, rd_d;
  logic          full, empty;

  assign full  = (cnt_q == CW'(DEPTH));
  assign empty = (cnt_q == '0);
  assign pop_ok  = pop && !empty;
  assign push_ok = push && (!full || pop_ok);
  assign head    = empty ? 8'h00 : store[rd_q];

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    if (push_ok) wr_d = (wr_q == PW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
    if (pop_ok)  rd_d = (rd_q == PW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
    if (push_ok && !pop_ok) cnt_d = cnt_q + 1'b1;
    if (pop_ok && !push_ok) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) store[wr_q] <= push_byte;
  end

  assert_fill_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));

  assert_full_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop) |=> (cnt_q == CW'(DEPTH)));

  assert_empty_pop_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && empty && !push) |=> (cnt_q == '0));

endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
  import uart_regbank_pkg::*;
#(
  parameter int IRQ_W = 11,
  parameter int CW    = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_en,
  input  logic [IRQ_W-1:0] clr_val,
  input  logic             tx_evt,
  input  logic             push_ok,
  input  logic             pop_ok,
  input  logic [CW-1:0]    cnt_q,
  input  logic [CW-1:0]    cnt_d,
  input  logic [CW-1:0]    trig,
  output logic [IRQ_W-1:0] raw_q
);

  logic [IRQ_W-1:0] raw_d;

  // clears apply first so that a same-cycle event survives
  always_comb begin
    raw_d = raw_q;
    if (clr_en) raw_d = raw_d & ~clr_val;
    if (tx_evt) raw_d[IRQ_TX] = 1'b1;
    if (push_ok) begin
      raw_d[IRQ_RT] = 1'b1;
      if ((cnt_q < trig) && (cnt_d >= trig)) raw_d[IRQ_RX] = 1'b1;
    end
    if (pop_ok) begin
      if (cnt_d < trig)  raw_d[IRQ_RX] = 1'b0;
      if (cnt_d == '0)   raw_d[IRQ_RT] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) raw_q <= '0;
    else        raw_q <= raw_d;
  end

  assert_tx_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_evt |=> raw_q[IRQ_TX]);

  assert_clear_tx_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && clr_val[IRQ_TX] && !tx_evt) |=> !raw_q[IRQ_TX]);

  assert_timeout_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
    raw_q[IRQ_RT] |-> (cnt_q != '0));

endmodule

// File: rtl/uart_id_rom.sv
module uart_id_rom
  import uart_regbank_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic [7:0]        id_byte
);

  logic [31:0] word;

  assign hit  = &addr[ADDR_W-1:3];
  assign word = addr[2] ? ID_CELL : ID_PERIPH;

  always_comb begin
    id_byte = 8'h00;
    for (int b = 0; b < 4; b++) begin
      if (addr[1:0] == 2'(b)) id_byte = word[8*b +: 8];
    end
  end

endmodule

// File: rtl/uart_regbank.sv
module uart_regbank
  import uart_regbank_pkg::*;
#(
  parameter int ADDR_W     = 10,
  parameter int DATA_W     = 16,
  parameter int FIFO_DEPTH = 16,
  parameter int IRQ_W      = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  input  logic              rx_in_valid,
  input  logic [7:0]        rx_in_byte,
  output logic              tx_valid,
  output logic [7:0]        tx_byte,
  output logic              irq
);

  localparam int CW = $clog2(FIFO_DEPTH + 1);

  // access decode
  logic acc_rd, acc_wr;
  logic sel_data, sel_estat, sel_flags, sel_idiv, sel_fdiv, sel_line;
  logic sel_ctrl, sel_lvl, sel_mask, sel_raw, sel_mskd, sel_clr;

  assign acc_rd    = bus_valid && !bus_write;
  assign acc_wr    = bus_valid &&  bus_write;
  assign sel_data  = (bus_addr == ADDR_W'(OFF_DATA));
  assign sel_estat = (bus_addr == ADDR_W'(OFF_ESTAT));
  assign sel_flags = (bus_addr == ADDR_W'(OFF_FLAGS));
  assign sel_idiv  = (bus_addr == ADDR_W'(OFF_IDIV));
  assign sel_fdiv  = (bus_addr == ADDR_W'(OFF_FDIV));
  assign sel_line  = (bus_addr == ADDR_W'(OFF_LINE));
  assign sel_ctrl  = (bus_addr == ADDR_W'(OFF_CTRL));
  assign sel_lvl   = (bus_addr == ADDR_W'(OFF_LVL));
  assign sel_mask  = (bus_addr == ADDR_W'(OFF_MASK));
  assign sel_raw   = (bus_addr == ADDR_W'(OFF_RAW));
  assign sel_mskd  = (bus_addr == ADDR_W'(OFF_MSKD));
  assign sel_clr   = (bus_addr == ADDR_W'(OFF_CLR));

  // configuration state
  logic [15:0]      idiv_q, idiv_d;
  logic [5:0]       fdiv_q, fdiv_d;
  logic [7:0]       line_q, line_d;
  logic [15:0]      ctrl_q, ctrl_d;
  logic [5:0]       lvl_q,  lvl_d;
  logic [IRQ_W-1:0] mask_q, mask_d;
  logic [3:0]       estat_q, estat_d;
  logic             loop_en;

  assign loop_en = ctrl_q[LOOP_BIT];

  // receive queue hookup
  logic          q_push, q_pop, q_push_ok, q_pop_ok;
  logic [7:0]    q_push_byte, q_head;
  logic [CW-1:0] q_cnt, q_cnt_d, trig;
  logic          wr_data;

  assign wr_data     = acc_wr && sel_data;
  assign q_push      = loop_en ? wr_data : rx_in_valid;
  assign q_push_byte = loop_en ? bus_wdata[7:0] : rx_in_byte;
  assign q_pop       = acc_rd && sel_data;
  assign trig        = CW'(rx_trigger(lvl_q[5:3], FIFO_DEPTH));

  uart_rxq #(.DEPTH(FIFO_DEPTH)) u_rxq (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (q_push),
    .push_byte (q_push_byte),
    .pop       (q_pop),
    .push_ok   (q_push_ok),
    .pop_ok    (q_pop_ok),
    .head      (q_head),
    .cnt_q     (q_cnt),
    .cnt_d     (q_cnt_d)
  );

  logic [IRQ_W-1:0] raw_q;

  uart_irq_ctrl #(.IRQ_W(IRQ_W), .CW(CW)) u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_en  (acc_wr && sel_clr),
    .clr_val (bus_wdata[IRQ_W-1:0]),
    .tx_evt  (wr_data),
    .push_ok (q_push_ok),
    .pop_ok  (q_pop_ok),
    .cnt_q   (q_cnt),
    .cnt_d   (q_cnt_d),
    .trig    (trig),
    .raw_q   (raw_q)
  );

  logic             id_hit;
  logic [7:0]       id_byte;

  uart_id_rom #(.ADDR_W(ADDR_W)) u_id (
    .addr    (bus_addr),
    .hit     (id_hit),
    .id_byte (id_byte)
  );

  // next-state for configuration and error status
  always_comb begin
    idiv_d = idiv_q;
    fdiv_d = fdiv_q;
    line_d = line_q;
    ctrl_d = ctrl_q;
    lvl_d  = lvl_q;
    mask_d = mask_q;
    if (acc_wr) begin
      if (sel_idiv) idiv_d = bus_wdata[15:0];
      if (sel_fdiv) fdiv_d = bus_wdata[5:0];
      if (sel_line) line_d = bus_wdata[7:0];
      if (sel_ctrl) ctrl_d = bus_wdata[15:0] & CTRL_KEEP;
      if (sel_lvl)  lvl_d  = bus_wdata[5:0];
      if (sel_mask) mask_d = bus_wdata[IRQ_W-1:0];
    end
  end

  always_comb begin
    estat_d = (acc_wr && sel_estat) ? 4'h0 : estat_q;
    if (q_push && !q_push_ok) estat_d[OVR_BIT] = 1'b1;
  end

  // read data mux
  logic [IRQ_W-1:0]  mskd;
  logic [DATA_W-1:0] rdata_d;
  logic [7:0]        flags;

  assign mskd = raw_q & mask_q;

  always_comb begin
    flags = 8'h00;
    flags[FL_TXEMPTY] = 1'b1;
    flags[FL_RXFULL]  = (q_cnt == CW'(FIFO_DEPTH));
    flags[FL_RXEMPTY] = (q_cnt == '0);
  end

  always_comb begin
    rdata_d = '0;
    if (sel_data) begin
      rdata_d[7:0]  = q_head;
      rdata_d[11:8] = estat_q;
    end
    else if (sel_estat) rdata_d[3:0]        = estat_q;
    else if (sel_flags) rdata_d[7:0]        = flags;
    else if (sel_idiv)  rdata_d[15:0]       = idiv_q;
    else if (sel_fdiv)  rdata_d[5:0]        = fdiv_q;
    else if (sel_line)  rdata_d[7:0]        = line_q;
    else if (sel_ctrl)  rdata_d[15:0]       = ctrl_q;
    else if (sel_lvl)   rdata_d[5:0]        = lvl_q;
    else if (sel_mask)  rdata_d[IRQ_W-1:0]  = mask_q;
    else if (sel_raw)   rdata_d[IRQ_W-1:0]  = raw_q;
    else if (sel_mskd)  rdata_d[IRQ_W-1:0]  = mskd;
    else if (id_hit)    rdata_d[7:0]        = id_byte;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idiv_q  <= '0;
      fdiv_q  <= '0;
      line_q  <= '0;
      ctrl_q  <= '0;
      lvl_q   <= LVL_RESET[5:0];
      mask_q  <= '0;
      estat_q <= '0;
    end else begin
      idiv_q  <= idiv_d;
      fdiv_q  <= fdiv_d;
      line_q  <= line_d;
      ctrl_q  <= ctrl_d;
      lvl_q   <= lvl_d;
      mask_q  <= mask_d;
      estat_q <= estat_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= acc_rd;
      if (acc_rd) rd_data <= rdata_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_valid <= 1'b0;
      tx_byte  <= '0;
    end else begin
      tx_valid <= wr_data && !loop_en;
      if (wr_data && !loop_en) tx_byte <= bus_wdata[7:0];
    end
  end

  assign irq = |mskd;

  assert_resp_follows_req_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(acc_rd));

  assert_tx_only_direct_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> $past(wr_data && !loop_en));

  assert_overrun_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (estat_q[OVR_BIT] && !(acc_wr && sel_estat)) |=> estat_q[OVR_BIT]);

  assert_loop_ignores_rx_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_in_valid && loop_en && !bus_valid) |=> (q_cnt == $past(q_cnt)));

endmodule

// File: tb/sim_uart_regbank.sv
module sim_uart_regbank;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 10;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          bus_valid, bus_write;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata;
  logic          rd_valid;
  logic [DW-1:0] rd_data;
  logic          rx_in_valid;
  logic [7:0]    rx_in_byte;
  logic          tx_valid;
  logic [7:0]    tx_byte;
  logic          irq;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_regbank u0 (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .rd_valid(rd_valid),
    .rd_data(rd_data), .rx_in_valid(rx_in_valid), .rx_in_byte(rx_in_byte),
    .tx_valid(tx_valid), .tx_byte(tx_byte), .irq(irq)
  );

  int n_vec = 0;
  int n_bad = 0;
  logic [DW-1:0] exp_q[$];
  string         tag_q[$];
  logic          seen_tx_v;
  logic [7:0]    seen_tx_b;
  bit            done = 0;

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // monitor: pop the scoreboard on every read response
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (exp_q.size() == 0) check("R11 unexpected response", rd_data, '1);
      else check(tag_q.pop_front(), rd_data, exp_q.pop_front());
    end
  end

  task automatic bus_rd(input int addr, input logic [DW-1:0] exp, input string tag);
    @(negedge clk);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = AW'(addr);
    @(negedge clk);
    bus_valid = 1'b0;
  endtask

  task automatic bus_wr(input int addr, input logic [DW-1:0] data);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = AW'(addr); bus_wdata = data;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
    seen_tx_v = tx_valid;
    seen_tx_b = tx_byte;
  endtask

  task automatic rx_feed(input logic [7:0] b);
    @(negedge clk);
    rx_in_valid = 1'b1; rx_in_byte = b;
    @(negedge clk);
    rx_in_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bus_valid = 1'b0; bus_write = 1'b0; bus_addr = '0;
    bus_wdata = '0; rx_in_valid = 1'b0; rx_in_byte = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    check("R1 irq low", {15'b0, irq}, 16'h0);
    bus_rd('h0D, 16'h0012, "R1 level select reset");
    bus_rd('h06, 16'h0090, "R1 flags reset");
    bus_rd('h0E, 16'h0000, "R1 mask reset");
    bus_rd('h0C, 16'h0000, "R1 control reset");
    bus_rd('h0F, 16'h0000, "R1 raw reset");

    // R2 write masks
    bus_wr('h0A, 16'hFFFF); bus_rd('h0A, 16'h003F, "R2 fractional divisor");
    bus_wr('h0B, 16'hFFFF); bus_rd('h0B, 16'h00FF, "R2 line control");
    bus_wr('h0C, 16'hFFFF); bus_rd('h0C, 16'hFFC7, "R2 control");
    bus_wr('h0D, 16'hFFFF); bus_rd('h0D, 16'h003F, "R2 level select");
    bus_wr('h0E, 16'hFFFF); bus_rd('h0E, 16'h07FF, "R2 mask");
    bus_wr('h09, 16'h1234); bus_rd('h09, 16'h1234, "R2 integer divisor");
    bus_wr('h0C, 16'h0000); bus_wr('h0D, 16'h0012); bus_wr('h0E, 16'h0000);

    // R3 direct transmit
    bus_wr('h00, 16'h01A5);
    check("R3 tx_valid", {15'b0, seen_tx_v}, 16'h1);
    check("R3 tx_byte", {8'b0, seen_tx_b}, 16'h00A5);
    bus_rd('h0F, 16'h0020, "R3 transmit raw bit");
    bus_rd('h06, 16'h0090, "R3 no loopback push");

    // R7 clear
    bus_wr('h11, 16'h0020);
    bus_rd('h0F, 16'h0000, "R7 clear transmit bit");
    bus_rd('h11, 16'h0000, "R7 clear reads zero");

    // R8 mask and irq
    bus_wr('h00, 16'h0042);
    check("R8 irq low while masked", {15'b0, irq}, 16'h0);
    bus_rd('h10, 16'h0000, "R8 masked status zero");
    bus_wr('h0E, 16'h0020);
    check("R8 irq high", {15'b0, irq}, 16'h1);
    bus_rd('h10, 16'h0020, "R8 masked status");
    bus_wr('h11, 16'h07FF);
    check("R8 irq low after clear", {15'b0, irq}, 16'h0);
    bus_wr('h0E, 16'h0000);

    // R6 timeout bit and R11 order with external bytes
    rx_feed(8'h11); rx_feed(8'h22); rx_feed(8'h33);
    bus_rd('h0F, 16'h0040, "R6 timeout set");
    bus_rd('h06, 16'h0080, "R5 neither full nor empty");
    bus_rd('h00, 16'h0011, "R11 order 1");
    bus_rd('h00, 16'h0022, "R11 order 2");
    bus_rd('h0F, 16'h0040, "R6 timeout held");
    bus_rd('h00, 16'h0033, "R11 order 3");
    bus_rd('h0F, 16'h0000, "R6 timeout cleared on empty");
    bus_rd('h06, 16'h0090, "R5 empty again");

    // R6 receive trigger at 8 (selector 2)
    for (int i = 0; i < 7; i++) rx_feed(8'(8'h60 + i));
    bus_rd('h0F, 16'h0040, "R6 below trigger");
    rx_feed(8'h67);
    bus_rd('h0F, 16'h0050, "R6 trigger crossed");
    bus_wr('h0E, 16'h0010);
    check("R8 irq from receive", {15'b0, irq}, 16'h1);
    bus_rd('h00, 16'h0060, "R11 first of eight");
    bus_rd('h0F, 16'h0040, "R6 receive cleared below trigger");
    check("R8 irq drops", {15'b0, irq}, 16'h0);
    for (int i = 1; i < 8; i++) bus_rd('h00, 16'(8'h60 + i), "R11 drain eight");
    bus_wr('h0E, 16'h0000);

    // R6 trigger at 2 (selector 0)
    bus_wr('h0D, 16'h0000);
    rx_feed(8'hA1);
    bus_rd('h0F, 16'h0040, "R6 low trigger one byte");
    rx_feed(8'hA2);
    bus_rd('h0F, 16'h0050, "R6 low trigger two bytes");
    bus_rd('h00, 16'h00A1, "R11 low trigger drain");
    bus_rd('h00, 16'h00A2, "R11 low trigger drain");
    bus_wr('h0D, 16'h0012);
    bus_wr('h11, 16'h07FF);

    // R4 overrun through loopback, R3 loopback path, R5 full
    bus_wr('h0C, 16'h0080);
    for (int i = 0; i < 16; i++) begin
      bus_wr('h00, 16'(8'h40 + i));
      if (i == 0) check("R3 loopback keeps tx idle", {15'b0, seen_tx_v}, 16'h0);
    end
    bus_rd('h06, 16'h00C0, "R5 full");
    bus_rd('h01, 16'h0000, "R4 no overrun yet");
    bus_wr('h00, 16'h007F);
    bus_rd('h01, 16'h0008, "R4 overrun flag");
    bus_rd('h00, 16'h0840, "R4 status in data read");
    bus_wr('h01, 16'h0000);
    bus_rd('h01, 16'h0000, "R4 write clears status");
    for (int i = 1; i < 16; i++) bus_rd('h00, 16'(8'h40 + i), "R4 drain after overrun");
    bus_rd('h06, 16'h0090, "R4 overflow byte dropped");

    // R12 external input ignored in loopback
    rx_feed(8'h99);
    bus_rd('h06, 16'h0090, "R12 rx ignored in loopback");
    bus_wr('h0C, 16'h0000);
    bus_wr('h11, 16'h07FF);

    // R11 empty read
    bus_rd('h00, 16'h0000, "R11 empty data read");
    bus_rd('h06, 16'h0090, "R11 empty read keeps fill");

    // R9 identification
    bus_rd('h3F8, 16'h0011, "R9 id 0");
    bus_rd('h3F9, 16'h0010, "R9 id 1");
    bus_rd('h3FA, 16'h0024, "R9 id 2");
    bus_rd('h3FB, 16'h0000, "R9 id 3");
    bus_rd('h3FC, 16'h000D, "R9 id 4");
    bus_rd('h3FD, 16'h00F0, "R9 id 5");
    bus_rd('h3FE, 16'h0005, "R9 id 6");
    bus_rd('h3FF, 16'h00B1, "R9 id 7");

    // R10 ignored writes and unassigned reads
    bus_wr('h06, 16'hFFFF);
    bus_wr('h0F, 16'hFFFF);
    bus_wr('h10, 16'hFFFF);
    bus_wr('h3F8, 16'hFFFF);
    bus_wr('h05, 16'hFFFF);
    bus_wr('h200, 16'hFFFF);
    bus_rd('h06, 16'h0090, "R10 flags unchanged");
    bus_rd('h0F, 16'h0000, "R10 raw unchanged");
    bus_rd('h3F8, 16'h0011, "R10 id unchanged");
    bus_rd('h05, 16'h0000, "R10 unassigned reads zero");
    bus_rd('h200, 16'h0000, "R10 unassigned high reads zero");
    bus_rd('h0D, 16'h0012, "R10 level select untouched");
    check("R10 irq low", {15'b0, irq}, 16'h0);

    repeat (3) @(negedge clk);
    check("R11 all responses seen", 16'(exp_q.size()), 16'h0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule